// File: doc/BRIEF.md
# Reloadable and Free-Running Tick Timer Unit

This unit holds three down-counting timers that reload themselves and one wide up-counter that runs freely. All of them sit behind a plain register bus. The first two reload timers are 16 bits wide and the third is 32 bits wide. Each reload timer counts one step per selected tick. The tick is either a slow enable pulse or a fast one. When a timer passes zero it reloads from its load register, or wraps to all ones in free mode. It also raises a sticky interrupt, which a write to its clear register removes. The 40-bit counter counts up on the fast tick only while its enable bit is set. It never interrupts. Software reads it as a low word and a high word.

Both tick rates come from outside as single-cycle enable pulses. The bus has a write strobe, a word address and write data. Read data is combinational from the address and always shows live state.

Register map, as word addresses. Reload timer k (k = 0, 1, 2) sits at 4k + sub:
- sub 0: load register.
- sub 1: live counter value, read-only.
- sub 2: control register.
- sub 3: clear register. A write of any data clears the pending flag, and a read returns 0.

The free counter uses address 12 for its low 32 bits (read-only) and address 13 for its high word. Address 13 reads bits 39:32 in bits 7:0 and the enable in bit 8. All other addresses read as 0.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, every counter, load register, control register and enable is zero. All interrupt outputs are low.
- R2: A write to a reload timer's load register while that timer is disabled also sets its counter, masked to the timer width. The value register returns the live counter, and bits above the timer width read as zero.
- R3: Control bit 7 enables counting. An enabled timer decrements by one in each cycle where its selected tick is high. Control bit 3 set selects the slow tick, and clear selects the fast tick. In a cycle without the selected tick, the counter holds.
- R4: Control bit 6 set selects periodic mode. A selected tick at count zero reloads the load value and sets the pending flag, so a load value of N−1 gives a period of N ticks.
- R5: With control bit 6 clear, a selected tick at count zero wraps the counter to all ones of its width and still sets the pending flag.
- R6: Each timer's interrupt output is its registered pending flag, which stays set until a write to its clear register. When an underflow and a clear write fall in the same cycle, the flag stays set.
- R7: A load write while the timer is enabled changes only the load register. The running count is kept, and the new value is used at the next reload.
- R8: The 40-bit free counter increments on each fast tick while bit 8 of its high-word register is set, and holds while that bit is clear. Address 12 reads bits 31:0. Address 13 reads bits 39:32 in bits 7:0 and the enable in bit 8.
- R9: The free counter ignores the slow tick. Writes to its low-word address change nothing.
- R10: A reload timer's control register reads back bits 7, 6 and 3 as written, with all other bits zero. The clear address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Slow tick enable pulse |
| tick_fast | input | 1 | Fast tick enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tmr_irq | output | 3 | Pending underflow interrupt of each reload timer |

## Verification
The assertions assume a single synchronous clock. They also assume the tick inputs and bus signals are stable around the edge. Reads have no side effects, so the properties put no limit on when a read may occur. The stimulus changes every input only on the falling edge. The stimulus drives ticks at random or in fixed patterns, issues arbitrary writes at random addresses, and includes writes to read-only and unused addresses. A behavioural model runs alongside the design. It supplies the expected read value and interrupt state in every cycle, and directed steps pin the underflow, clear-collision and free-counter cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int REGS_PER_TMR  = 4;
   localparam int CTRL_EN_BIT   = 7;
   localparam int CTRL_PER_BIT  = 6;
   localparam int CTRL_SLOW_BIT = 3;
   localparam int FREE_EN_BIT   = 8;

   localparam logic [1:0] SUB_LOAD  = 2'd0;
   localparam logic [1:0] SUB_VALUE = 2'd1;
   localparam logic [1:0] SUB_CTRL  = 2'd2;
   localparam logic [1:0] SUB_CLEAR = 2'd3;

   typedef struct packed {
      logic en;
      logic periodic;
      logic slow;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_reload.sv
module tmr_reload
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_slow,
   input  logic             tick_fast,
   input  logic             wr_en,
   input  logic [1:0]       sub_addr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   generate
      if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_width
         $error("tmr_reload: CNT_W must lie in 1..BUS_W");
      end
      if (BUS_W <= CTRL_EN_BIT) begin : g_bad_bus
         $error("tmr_reload: BUS_W too narrow for control bits");
      end
   endgenerate

   logic [CNT_W-1:0] load_q, cnt_q, cnt_d;
   tmr_ctrl_t        ctrl_q;
   logic             pend_q;
   logic             tick, step, at_zero;
   logic             load_wr, ctrl_wr, clr_wr;

   assign tick    = ctrl_q.slow ? tick_slow : tick_fast;
   assign step    = ctrl_q.en && tick;
   assign at_zero = (cnt_q == '0);
   assign load_wr = wr_en && (sub_addr == SUB_LOAD);
   assign ctrl_wr = wr_en && (sub_addr == SUB_CTRL);
   assign clr_wr  = wr_en && (sub_addr == SUB_CLEAR);

   always_comb begin
      cnt_d = cnt_q;
      if (step) begin
         if (at_zero) cnt_d = ctrl_q.periodic ? load_q : ALL_ONES;
         else         cnt_d = cnt_q - ONE;
      end else if (load_wr && !ctrl_q.en) begin
         cnt_d = wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (load_wr) load_q <= wdata[CNT_W-1:0];
         if (ctrl_wr) begin
            ctrl_q.en       <= wdata[CTRL_EN_BIT];
            ctrl_q.periodic <= wdata[CTRL_PER_BIT];
            ctrl_q.slow     <= wdata[CTRL_SLOW_BIT];
         end
         if (step && at_zero) pend_q <= 1'b1;
         else if (clr_wr)     pend_q <= 1'b0;
      end
   end

   assign irq = pend_q;

   always_comb begin
      rdata = '0;
      case (sub_addr)
         SUB_LOAD:  rdata[CNT_W-1:0] = load_q;
         SUB_VALUE: rdata[CNT_W-1:0] = cnt_q;
         SUB_CTRL: begin
            rdata[CTRL_EN_BIT]   = ctrl_q.en;
            rdata[CTRL_PER_BIT]  = ctrl_q.periodic;
            rdata[CTRL_SLOW_BIT] = ctrl_q.slow;
         end
         default: rdata = '0;
      endcase
   end

   // R4
   periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && ctrl_q.periodic && tick && cnt_q == '0) |=> (cnt_q == $past(load_q)));
   // R5
   free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && !ctrl_q.periodic && tick && cnt_q == '0) |=> (cnt_q == ALL_ONES));
   // R6
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && tick && cnt_q == '0) |=> irq);
   // R6
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sub_addr == SUB_CLEAR && !(ctrl_q.en && tick && cnt_q == '0)) |=> !irq);
   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ctrl_q.en && tick) && !(wr_en && sub_addr == SUB_LOAD && !ctrl_q.en)) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
   import tmr_pkg::*;
#(
   parameter int CNT_W = 40,
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_hi,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rd_lo,
   output logic [BUS_W-1:0] rd_hi
);
   localparam int HI_W = CNT_W - BUS_W;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (HI_W < 1 || HI_W > FREE_EN_BIT) begin : g_bad_width
         $error("tmr_freerun: upper part must fit below the enable bit");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (en_q && tick) cnt_q <= cnt_q + ONE;
         if (wr_hi)        en_q  <= wdata[FREE_EN_BIT];
      end
   end

   assign rd_lo = cnt_q[BUS_W-1:0];

   always_comb begin
      rd_hi              = '0;
      rd_hi[HI_W-1:0]    = cnt_q[CNT_W-1:BUS_W];
      rd_hi[FREE_EN_BIT] = en_q;
   end

   // R8
   free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick) |=> (cnt_q == $past(cnt_q) + ONE));
   // R9
   free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_q && tick) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
   import tmr_pkg::*;
#(
   parameter int NUM_NARROW = 2,
   parameter int NUM_WIDE   = 1,
   parameter int NARROW_W   = 16,
   parameter int WIDE_W     = 32,
   parameter int FREE_W     = 40,
   parameter int BUS_W      = 32,
   parameter int ADDR_W     = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick_slow,
   input  logic                           tick_fast,
   input  logic                           bus_wr,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [BUS_W-1:0]               bus_wdata,
   output logic [BUS_W-1:0]               bus_rdata,
   output logic [NUM_NARROW+NUM_WIDE-1:0] tmr_irq
);
   localparam int NUM_RELOAD = NUM_NARROW + NUM_WIDE;
   localparam int FREE_BASE  = NUM_RELOAD * REGS_PER_TMR;
   localparam logic [ADDR_W-1:0] FREE_LO = ADDR_W'(FREE_BASE);
   localparam logic [ADDR_W-1:0] FREE_HI = ADDR_W'(FREE_BASE + 1);

   generate
      if ((1 << ADDR_W) < FREE_BASE + 2) begin : g_bad_addr
         $error("tick_timer_unit: ADDR_W too small for register map");
      end
      if (NUM_RELOAD < 1) begin : g_bad_count
         $error("tick_timer_unit: need at least one reload timer");
      end
   endgenerate

   logic [BUS_W-1:0] rd_vec [NUM_RELOAD];
   logic [BUS_W-1:0] free_lo, free_hi;

   for (genvar gi = 0; gi < NUM_RELOAD; gi++) begin : g_tmr
      localparam int W = (gi < NUM_NARROW) ? NARROW_W : WIDE_W;
      logic sel;
      assign sel = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(gi));
      tmr_reload #(.CNT_W(W), .BUS_W(BUS_W)) u_tmr (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_slow (tick_slow),
         .tick_fast (tick_fast),
         .wr_en     (bus_wr && sel),
         .sub_addr  (bus_addr[1:0]),
         .wdata     (bus_wdata),
         .rdata     (rd_vec[gi]),
         .irq       (tmr_irq[gi])
      );
   end

   tmr_freerun #(.CNT_W(FREE_W), .BUS_W(BUS_W)) u_free (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_fast),
      .wr_hi (bus_wr && bus_addr == FREE_HI),
      .wdata (bus_wdata),
      .rd_lo (free_lo),
      .rd_hi (free_hi)
   );

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_RELOAD; i++) begin
         if (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(i)) bus_rdata = rd_vec[i];
      end
      if (bus_addr == FREE_LO) bus_rdata = free_lo;
      if (bus_addr == FREE_HI) bus_rdata = free_hi;
   end
endmodule

// File: tb/tick_timer_unit_tb.sv
`timescale 1ns/1ps
module tick_timer_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_slow = 1'b0, tick_fast = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  tmr_irq;

   int n_chk = 0, n_fail = 0;
   bit started = 0, done = 0;

   always #2 clk = ~clk;

   tick_timer_unit u_dut (
      .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tmr_irq(tmr_irq));

   // behavioural reference
   longint m_load[3], m_cnt[3], f_cnt;
   bit     m_en[3], m_per[3], m_slow[3], m_pend[3], f_en;

   function automatic longint wmask(int i);
      return (i < 2) ? 64'hFFFF : 64'hFFFF_FFFF;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin
            m_load[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_per[i] = 0; m_slow[i] = 0; m_pend[i] = 0;
         end
         f_cnt = 0; f_en = 0;
      end else begin
         for (int i = 0; i < 3; i++) begin
            bit tk, uf, hit;
            int sub;
            hit = bus_wr && (int'(bus_addr) / 4 == i);
            sub = int'(bus_addr) % 4;
            tk  = m_slow[i] ? tick_slow : tick_fast;
            uf  = 0;
            if (m_en[i] && tk) begin
               if (m_cnt[i] == 0) begin
                  uf = 1;
                  m_cnt[i] = m_per[i] ? m_load[i] : wmask(i);
               end else m_cnt[i] = m_cnt[i] - 1;
            end else if (hit && sub == 0 && !m_en[i]) m_cnt[i] = longint'(bus_wdata) & wmask(i);
            if (uf) m_pend[i] = 1;
            else if (hit && sub == 3) m_pend[i] = 0;
            if (hit && sub == 0) m_load[i] = longint'(bus_wdata) & wmask(i);
            if (hit && sub == 2) begin
               m_en[i] = bus_wdata[7]; m_per[i] = bus_wdata[6]; m_slow[i] = bus_wdata[3];
            end
         end
         if (f_en && tick_fast) f_cnt = (f_cnt + 1) & 64'hFF_FFFF_FFFF;
         if (bus_wr && bus_addr == 4'd13) f_en = bus_wdata[8];
      end
   end

   function automatic longint mread(int a);
      int i, sub;
      i = a / 4; sub = a % 4;
      if (a == 12) return f_cnt & 64'hFFFF_FFFF;
      if (a == 13) return (f_cnt >> 32) | (longint'(f_en) << 8);
      if (i > 2) return 0;
      case (sub)
         0: return m_load[i];
         1: return m_cnt[i];
         2: return (longint'(m_en[i]) << 7) | (longint'(m_per[i]) << 6) | (longint'(m_slow[i]) << 3);
         default: return 0;
      endcase
   endfunction

   function automatic string rtag(int a);
      if (a == 12 || a == 13) return "R8";
      if (a > 13) return "R9";
      if (a % 4 >= 2) return "R10";
      return "R3";
   endfunction

   task automatic chk(string tag, longint got, longint exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always begin
      @(negedge clk);
      #1;
      if (started && !done) begin
         chk("R6 irq", longint'(tmr_irq), longint'({m_pend[2], m_pend[1], m_pend[0]}));
         chk(rtag(int'(bus_addr)), longint'(bus_rdata), mread(int'(bus_addr)));
      end
   end

   task automatic step(bit wr, int a, logic [31:0] d, bit ts, bit tf);
      bus_wr = wr; bus_addr = 4'(a); bus_wdata = d; tick_slow = ts; tick_fast = tf;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 0; tick_slow = 0; tick_fast = 0;
   endtask

   task automatic peek(string tag, int a, longint exp);
      bus_addr = 4'(a);
      #1.5;
      chk(tag, longint'(bus_rdata), exp);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog R1: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      started = 1;
      // R1 reset state
      peek("R1 value", 1, 0);
      chk("R1 irq", longint'(tmr_irq), 0);
      peek("R1 free", 13, 0);
      // R2 load while disabled sets counter; high bits masked
      step(1, 0, 32'hABCD_0002, 0, 0);
      peek("R2 value", 1, 2);
      // R3 enable periodic slow: 0xC8
      step(1, 2, 32'hC8, 0, 0);
      step(0, 1, 0, 1, 0);
      step(0, 1, 0, 1, 0);
      peek("R3 count", 1, 0);
      step(0, 1, 0, 0, 1);
      peek("R3 fast ignored", 1, 0);
      // R4 reload at zero and flag
      step(0, 1, 0, 1, 0);
      peek("R4 reload", 1, 2);
      chk("R4 irq", longint'(tmr_irq[0]), 1);
      // R6 clear
      step(1, 3, 0, 0, 0);
      chk("R6 clear", longint'(tmr_irq[0]), 0);
      step(0, 1, 0, 1, 0);
      step(0, 1, 0, 1, 0);
      step(1, 3, 0, 1, 0);
      chk("R6 collision", longint'(tmr_irq[0]), 1);
      // R7 load while running
      step(1, 0, 32'd9, 0, 0);
      peek("R7 count kept", 1, 2);
      peek("R7 load", 0, 9);
      // R5 free mode wrap: 0x88
      step(1, 2, 32'h88, 0, 0);
      peek("R10 ctrl", 2, 32'h88);
      step(1, 3, 0, 0, 0);
      step(0, 1, 0, 1, 0);
      step(0, 1, 0, 1, 0);
      step(0, 1, 0, 1, 0);
      peek("R5 wrap", 1, 64'hFFFF);
      chk("R5 irq", longint'(tmr_irq[0]), 1);
      peek("R10 clear reads zero", 3, 0);
      // R8 free counter
      step(1, 13, 32'h100, 0, 0);
      for (int k = 0; k < 5; k++) step(0, 12, 0, 0, 1);
      peek("R8 low", 12, 5);
      peek("R8 high", 13, 32'h100);
      // R9 slow tick and low-word write ignored
      for (int k = 0; k < 3; k++) step(0, 12, 0, 1, 0);
      peek("R9 slow", 12, 5);
      step(1, 12, 32'hABCD, 0, 0);
      peek("R9 low write", 12, 5);
      step(1, 13, 0, 0, 0);
      step(0, 12, 0, 0, 1);
      peek("R8 disabled hold", 12, 5);
      // random traffic, compared every cycle with the model
      for (int k = 0; k < 6000; k++) begin
         bit w;
         int a;
         logic [31:0] d;
         w = ($urandom % 8) == 0;
         a = $urandom % 16;
         case ($urandom % 4)
            0: d = $urandom;
            1: d = $urandom % 6;
            2: d = {24'h0, $urandom % 2 == 0, $urandom % 2 == 0, 2'b00, $urandom % 2 == 0, 3'b000};
            default: d = 32'h100 * ($urandom % 2);
         endcase
         step(w, a, d, ($urandom % 4) == 0, ($urandom % 2) == 0);
      end
      done = 1;
      summary();
      $finish;
   end
endmodule